// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank Tracker

This block watches the command pins of a DDR SDRAM device and needs no handshake. On every rising clock edge it samples chip select, the three strobes (row, column, write), clock enable, the bank address and the address bus. It turns them into one decoded command per cycle. It keeps the open or closed state of each bank and the row that bank holds, and it closes auto-precharged banks once a burst-length delay has run out. It also follows self-refresh and captures writes to the two mode registers.

Commands that break the protocol raise a one-cycle error pulse with a reason code. These are: an access to a closed bank, activating a bank that is already open, a refresh while any bank is open, a burst stop with no plain read burst in flight, and a mode-register load to a reserved register. An offending command leaves bank state as it was. Every output is registered, so the effect of the command sampled at clock edge N shows on the outputs just after edge N.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: With `cs_n` high the cycle decodes as no-op (code 0) whatever the other pins are. With `cs_n` low, {ras_n,cas_n,we_n} decodes as: 111 no-op 0, 011 activate 1, 101 read 2, 100 write 3, 110 burst stop 4, 010 precharge 5, 001 refresh (code 6 if `cke` is high, self-refresh entry 7 if `cke` is low), 000 mode load 8. A no-op changes no state.
- R2: Activate to a closed bank opens the bank selected by `ba` and stores `addr[ROW_W-1:0]` as its row on `bank_row[ba*ROW_W +: ROW_W]`.
- R3: A read or write with `addr[10]` low leaves the bank open indefinitely.
- R4: A read or write with `addr[10]` high to an open bank keeps it open, then closes it exactly `AP_DELAY` edges after the command edge (default 4).
- R5: Burst stop is legal only on one of the `BURST_CYC` edges (default 4) that follow a read with `addr[10]` low. A legal burst stop ends that window. Any other burst stop, including one after a write or after an auto-precharged read, raises error code 4.
- R6: Precharge with `addr[10]` low closes only bank `ba`. With `addr[10]` high it closes every bank and ignores `ba`.
- R7: A read or write to a closed bank raises error code 1, and activate to an open bank raises error code 2. In both cases bank state does not change. `err` is high only in the cycle after the offending command.
- R8: Mode load with `ba`=0 pulses `mr_we` for one cycle with `mr_sel`=0 and `mr_opcode`=`addr`. With `ba`=1 it does the same with `mr_sel`=1. `ba` of 2 or 3 raises error code 5, gives no pulse and leaves `mr_sel`/`mr_opcode` unchanged.
- R9: Refresh or self-refresh entry while any bank is open raises error code 3, and no refresh or entry takes place.
- R10: Self-refresh entry with all banks closed sets `self_ref`. While `self_ref` is set, every command decodes as no-op and is ignored. The first edge with `cke` high clears `self_ref`, and its command is also ignored.
- R11: Synchronous active-high `rst` closes all banks and clears `self_ref`, `err`, `mr_we` and the command code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; pins sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row, column, flag and op-code bus |
| cmd_code | output | 4 | Decoded command of the last sampled cycle |
| bank_open | output | 4 | One open flag per bank |
| bank_row | output | 52 | Open row per bank, bank 0 in the low bits |
| mr_we | output | 1 | One-cycle mode-register write strobe |
| mr_sel | output | 1 | 0 = mode register, 1 = extended mode register |
| mr_opcode | output | 13 | Last captured op-code |
| err | output | 1 | Protocol violation pulse |
| err_code | output | 3 | Reason for the violation, 0 when none |
| self_ref | output | 1 | High while in self-refresh |

## Verification
A wrong bank flag shows at the ports within one cycle as a spurious error code 1, 2 or 3 on the next access, activate or refresh. A miscounted auto-precharge delay moves the fall of `bank_open` by whole cycles, and the bench catches this by sampling each edge of the window. A burst-window fault shows up as a missing or extra code 4 on a burst stop placed at the first edge past the window or on its last edge. A stuck self-refresh state shows up as an activate that either still opens a bank while it should be ignored, or opens nothing after `cke` has returned.

// File: rtl/ddrmon_pkg.sv
`timescale 1ns/1ps
package ddrmon_pkg;
   typedef enum logic [3:0] {
      CMD_NOP  = 4'd0,
      CMD_ACT  = 4'd1,
      CMD_RD   = 4'd2,
      CMD_WR   = 4'd3,
      CMD_BST  = 4'd4,
      CMD_PRE  = 4'd5,
      CMD_REF  = 4'd6,
      CMD_SREF = 4'd7,
      CMD_LMR  = 4'd8
   } cmd_e;

   typedef enum logic [2:0] {
      E_NONE       = 3'd0,
      E_ACC_CLOSED = 3'd1,
      E_ACT_OPEN   = 3'd2,
      E_REF_OPEN   = 3'd3,
      E_BST        = 3'd4,
      E_MR_RSVD    = 3'd5
   } errc_e;
endpackage

// File: rtl/ddrmon_decode.sv
`timescale 1ns/1ps
module ddrmon_decode
   import ddrmon_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   input  logic cke,
   output cmd_e cmd
);
   always_comb begin
      cmd = CMD_NOP;
      if (!cs_n) begin
         unique case ({ras_n, cas_n, we_n})
            3'b111: cmd = CMD_NOP;
            3'b011: cmd = CMD_ACT;
            3'b101: cmd = CMD_RD;
            3'b100: cmd = CMD_WR;
            3'b110: cmd = CMD_BST;
            3'b010: cmd = CMD_PRE;
            3'b001: cmd = cke ? CMD_REF : CMD_SREF;
            default: cmd = CMD_LMR;
         endcase
      end
   end
endmodule

// File: rtl/ddrmon_bank.sv
`timescale 1ns/1ps
module ddrmon_bank #(
   parameter int ROW_W    = 13,
   parameter int AP_DELAY = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             act_go,
   input  logic             acc_go,
   input  logic             acc_ap,
   input  logic             close_go,
   input  logic [ROW_W-1:0] row_in,
   output logic             open_o,
   output logic [ROW_W-1:0] row_o
);
   localparam int CW = $clog2(AP_DELAY + 1);

   generate
      if (AP_DELAY < 1) begin : g_bad_delay
         $error("AP_DELAY must be at least 1");
      end
   endgenerate

   logic             open_q;
   logic             pend_q;
   logic [CW-1:0]    cnt_q;
   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         open_q <= 1'b0;
         pend_q <= 1'b0;
         cnt_q  <= '0;
         row_q  <= '0;
      end else if (act_go) begin
         open_q <= 1'b1;
         pend_q <= 1'b0;
         row_q  <= row_in;
      end else if (close_go) begin
         open_q <= 1'b0;
         pend_q <= 1'b0;
      end else if (acc_go) begin
         pend_q <= acc_ap;
         cnt_q  <= CW'(AP_DELAY - 1);
      end else if (pend_q) begin
         if (cnt_q == '0) begin
            open_q <= 1'b0;
            pend_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign open_o = open_q;
   assign row_o  = row_q;

   // R4: a pending auto precharge only exists on an open bank
   assert_pend_on_open_R4: assert property (@(posedge clk) disable iff (rst)
      pend_q |-> open_q);

   // R3: an open bank with nothing pending and no precharge stays open
   assert_stays_open_R3: assert property (@(posedge clk) disable iff (rst)
      (open_q && !pend_q && !close_go && !(acc_go && acc_ap)) |=> open_q);
endmodule

// File: rtl/ddrmon_burst.sv
`timescale 1ns/1ps
module ddrmon_burst #(
   parameter int BURST_CYC = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic kill,
   output logic ok
);
   localparam int LW = $clog2(BURST_CYC + 1);

   generate
      if (BURST_CYC < 1) begin : g_bad_burst
         $error("BURST_CYC must be at least 1");
      end
   endgenerate

   logic [LW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (rst)                 left_q <= '0;
      else if (start)          left_q <= LW'(BURST_CYC);
      else if (kill)           left_q <= '0;
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign ok = (left_q != '0);

   // R5: a plain read always opens a burst-stop window on the next edge
   assert_window_opens_R5: assert property (@(posedge clk) disable iff (rst)
      (start && !kill) |=> ok);
endmodule

// File: rtl/ddr_cmd_tracker.sv
`timescale 1ns/1ps
module ddr_cmd_tracker
   import ddrmon_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 13,
   parameter int ADDR_W    = 13,
   parameter int AP_BIT    = 10,
   parameter int AP_DELAY  = 4,
   parameter int BURST_CYC = 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       cs_n,
   input  logic                       ras_n,
   input  logic                       cas_n,
   input  logic                       we_n,
   input  logic                       cke,
   input  logic [1:0]                 ba,
   input  logic [ADDR_W-1:0]          addr,
   output logic [3:0]                 cmd_code,
   output logic [NUM_BANKS-1:0]       bank_open,
   output logic [NUM_BANKS*ROW_W-1:0] bank_row,
   output logic                       mr_we,
   output logic                       mr_sel,
   output logic [ADDR_W-1:0]          mr_opcode,
   output logic                       err,
   output logic [2:0]                 err_code,
   output logic                       self_ref
);
   localparam int BA_W = $clog2(NUM_BANKS);

   generate
      if (NUM_BANKS != 4) begin : g_bad_banks
         $error("port ba is 2 bits wide, NUM_BANKS must be 4");
      end
      if (ADDR_W <= AP_BIT) begin : g_bad_apbit
         $error("AP_BIT must lie inside the address bus");
      end
      if (ROW_W > ADDR_W) begin : g_bad_row
         $error("ROW_W cannot exceed ADDR_W");
      end
   endgenerate

   cmd_e cmd_raw;
   cmd_e cmd_eff;

   ddrmon_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cke   (cke),
      .cmd   (cmd_raw)
   );

   logic                 sref_q;
   logic [BA_W-1:0]      bsel;
   logic                 ap_flag;
   logic                 any_open;
   logic                 sel_open;
   logic                 bst_ok;
   logic                 legal;
   errc_e                errc_n;
   logic [NUM_BANKS-1:0] open_w;
   logic [ROW_W-1:0]     row_w [NUM_BANKS];

   assign cmd_eff  = sref_q ? CMD_NOP : cmd_raw;
   assign bsel     = ba;
   assign ap_flag  = addr[AP_BIT];
   assign any_open = |open_w;
   assign sel_open = open_w[bsel];

   always_comb begin
      errc_n = E_NONE;
      unique case (cmd_eff)
         CMD_ACT:           if (sel_open)  errc_n = E_ACT_OPEN;
         CMD_RD, CMD_WR:    if (!sel_open) errc_n = E_ACC_CLOSED;
         CMD_BST:           if (!bst_ok)   errc_n = E_BST;
         CMD_REF, CMD_SREF: if (any_open)  errc_n = E_REF_OPEN;
         CMD_LMR:           if (ba > 2'd1) errc_n = E_MR_RSVD;
         default:           errc_n = E_NONE;
      endcase
   end
   assign legal = (errc_n == E_NONE);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
         logic hit;
         assign hit = (bsel == BA_W'(gi));
         ddrmon_bank #(
            .ROW_W    (ROW_W),
            .AP_DELAY (AP_DELAY)
         ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .act_go   (legal && cmd_eff == CMD_ACT && hit),
            .acc_go   (legal && (cmd_eff == CMD_RD || cmd_eff == CMD_WR) && hit),
            .acc_ap   (ap_flag),
            .close_go (cmd_eff == CMD_PRE && (ap_flag || hit)),
            .row_in   (addr[ROW_W-1:0]),
            .open_o   (open_w[gi]),
            .row_o    (row_w[gi])
         );
         assign bank_row[gi*ROW_W +: ROW_W] = row_w[gi];

         // R2: a bank only opens on a decoded activate
         assert_open_by_act_R2: assert property (@(posedge clk) disable iff (rst)
            $rose(bank_open[gi]) |-> (cmd_code == CMD_ACT && !err));
      end
   endgenerate

   ddrmon_burst #(
      .BURST_CYC (BURST_CYC)
   ) u_burst (
      .clk   (clk),
      .rst   (rst),
      .start (legal && cmd_eff == CMD_RD && !ap_flag),
      .kill  ((legal && cmd_eff == CMD_RD && ap_flag) ||
              (legal && cmd_eff == CMD_WR) || cmd_eff == CMD_BST),
      .ok    (bst_ok)
   );

   cmd_e              cmd_q;
   errc_e             errc_q;
   logic              err_q;
   logic              mrwe_q;
   logic              mrsel_q;
   logic [ADDR_W-1:0] mrop_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_q   <= CMD_NOP;
         errc_q  <= E_NONE;
         err_q   <= 1'b0;
         mrwe_q  <= 1'b0;
         mrsel_q <= 1'b0;
         mrop_q  <= '0;
         sref_q  <= 1'b0;
      end else begin
         cmd_q  <= cmd_eff;
         errc_q <= errc_n;
         err_q  <= !legal;
         mrwe_q <= legal && cmd_eff == CMD_LMR;
         if (legal && cmd_eff == CMD_LMR) begin
            mrsel_q <= ba[0];
            mrop_q  <= addr;
         end
         if (sref_q) begin
            if (cke) sref_q <= 1'b0;
         end else if (legal && cmd_eff == CMD_SREF) begin
            sref_q <= 1'b1;
         end
      end
   end

   assign cmd_code  = cmd_q;
   assign bank_open = open_w;
   assign mr_we     = mrwe_q;
   assign mr_sel    = mrsel_q;
   assign mr_opcode = mrop_q;
   assign err       = err_q;
   assign err_code  = errc_q;
   assign self_ref  = sref_q;

   // R8: the strobe only follows an accepted mode load
   assert_mr_strobe_R8: assert property (@(posedge clk) disable iff (rst)
      mr_we |-> (cmd_code == CMD_LMR && !err));

   // R7: the error pulse always carries a reason, and a reason never stands alone
   assert_err_reason_R7: assert property (@(posedge clk) disable iff (rst)
      err == (err_code != 3'd0));

   // R10: entering self-refresh needs every bank closed
   assert_sref_idle_R10: assert property (@(posedge clk) disable iff (rst)
      $rose(self_ref) |-> (bank_open == '0 && cmd_code == CMD_SREF));

   // R10: commands sampled during self-refresh are ignored
   assert_sref_ignores_R10: assert property (@(posedge clk) disable iff (rst)
      self_ref |=> (cmd_code == CMD_NOP && !err));
endmodule

// File: tb/sim_ddr_cmd_tracker.sv
`timescale 1ns/1ps
module sim_ddr_cmd_tracker;
   localparam int AP_D  = 4;
   localparam int BST_W = 4;

   localparam logic [3:0] C_DES = 4'b1111;
   localparam logic [3:0] C_NOP = 4'b0111;
   localparam logic [3:0] C_ACT = 4'b0011;
   localparam logic [3:0] C_RD  = 4'b0101;
   localparam logic [3:0] C_WR  = 4'b0100;
   localparam logic [3:0] C_BST = 4'b0110;
   localparam logic [3:0] C_PRE = 4'b0010;
   localparam logic [3:0] C_REF = 4'b0001;
   localparam logic [3:0] C_LMR = 4'b0000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic        cke = 1'b1;
   logic [1:0]  ba = '0;
   logic [12:0] addr = '0;
   logic [3:0]  cmd_code;
   logic [3:0]  bank_open;
   logic [51:0] bank_row;
   logic        mr_we, mr_sel, err, self_ref;
   logic [12:0] mr_opcode;
   logic [2:0]  err_code;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   ddr_cmd_tracker #(.AP_DELAY(AP_D), .BURST_CYC(BST_W)) u0 (
      .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .cmd_code(cmd_code),
      .bank_open(bank_open), .bank_row(bank_row), .mr_we(mr_we),
      .mr_sel(mr_sel), .mr_opcode(mr_opcode), .err(err),
      .err_code(err_code), .self_ref(self_ref)
   );

   function automatic logic [12:0] row_of(input int b);
      return 13'((b * 2749 + 301) % 8192);
   endfunction

   function automatic logic [3:0] code_of(input logic [3:0] c, input logic k);
      if (c[3]) return 4'd0;
      case (c[2:0])
         3'b111: return 4'd0;
         3'b011: return 4'd1;
         3'b101: return 4'd2;
         3'b100: return 4'd3;
         3'b110: return 4'd4;
         3'b010: return 4'd5;
         3'b001: return k ? 4'd6 : 4'd7;
         default: return 4'd8;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cmd(input logic [3:0] c, input logic k, input logic [1:0] b,
                      input logic [12:0] a);
      @(negedge clk);
      {cs_n, ras_n, cas_n, we_n} = c;
      cke  = k;
      ba   = b;
      addr = a;
      @(posedge clk);
      #1;
   endtask

   task automatic nop();
      cmd(C_NOP, 1'b1, 2'd0, 13'd0);
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #400000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R11 reset open", 32'(bank_open), 0);
      chk("R11 reset err", 32'(err), 0);
      chk("R11 reset code", 32'(cmd_code), 0);
      chk("R11 reset mr_we", 32'(mr_we), 0);
      chk("R11 reset self_ref", 32'(self_ref), 0);

      // R1 sweep over all sixteen pin combinations with cke high
      for (int c = 0; c < 16; c++) begin
         logic [3:0] cc;
         logic [3:0] ex;
         cc = 4'(c);
         ex = code_of(cc, 1'b1);
         cmd(cc, 1'b1, 2'd0, 13'h0011);
         chk($sformatf("R1 code for %b", cc), 32'(cmd_code), 32'(ex));
         chk($sformatf("R1 err for %b", cc), 32'(err),
             (ex == 4'd2 || ex == 4'd3 || ex == 4'd4) ? 1 : 0);
         chk($sformatf("R1 open for %b", cc), 32'(bank_open), (ex == 4'd1) ? 1 : 0);
         cmd(C_PRE, 1'b1, 2'd0, 13'h0400);
      end
      cmd(C_DES & 4'b1000, 1'b1, 2'd3, 13'h1FFF);
      chk("R1 deselect no effect", 32'(bank_open), 0);

      // R2 open each bank with its own row
      for (int b = 0; b < 4; b++) begin
         cmd(C_ACT, 1'b1, 2'(b), row_of(b));
         chk("R2 activate err", 32'(err), 0);
         chk("R2 open mask", 32'(bank_open), (1 << (b + 1)) - 1);
      end
      for (int b = 0; b < 4; b++)
         chk("R2 row", 32'(bank_row[b*13 +: 13]), 32'(row_of(b)));

      // R7 activate to an open bank
      cmd(C_ACT, 1'b1, 2'd2, 13'h0AAA);
      chk("R7 act-open err", 32'(err), 1);
      chk("R7 act-open code", 32'(err_code), 2);
      chk("R7 act-open row kept", 32'(bank_row[26 +: 13]), 32'(row_of(2)));
      nop();
      chk("R7 err one cycle", 32'(err), 0);

      // R3 plain read keeps bank open
      cmd(C_RD, 1'b1, 2'd1, 13'h0005);
      chk("R3 read err", 32'(err), 0);
      repeat (2 * AP_D) nop();
      chk("R3 still open", 32'(bank_open), 4'hF);

      // R5 burst stop rules
      cmd(C_RD, 1'b1, 2'd1, 13'h0000);
      cmd(C_BST, 1'b1, 2'd0, 13'h0000);
      chk("R5 stop after read", 32'(err), 0);
      cmd(C_BST, 1'b1, 2'd0, 13'h0000);
      chk("R5 second stop", 32'(err_code), 4);
      cmd(C_RD, 1'b1, 2'd1, 13'h0000);
      repeat (BST_W - 1) nop();
      cmd(C_BST, 1'b1, 2'd0, 13'h0000);
      chk("R5 stop on last edge", 32'(err), 0);
      cmd(C_RD, 1'b1, 2'd1, 13'h0000);
      repeat (BST_W) nop();
      cmd(C_BST, 1'b1, 2'd0, 13'h0000);
      chk("R5 stop past window", 32'(err_code), 4);
      cmd(C_WR, 1'b1, 2'd0, 13'h0000);
      cmd(C_BST, 1'b1, 2'd0, 13'h0000);
      chk("R5 stop after write", 32'(err_code), 4);

      // R4 auto precharge on read, window checked edge by edge
      cmd(C_RD, 1'b1, 2'd3, 13'h0400);
      chk("R4 read-ap open", 32'(bank_open[3]), 1);
      cmd(C_BST, 1'b1, 2'd0, 13'h0000);
      chk("R5 stop after read-ap", 32'(err_code), 4);
      chk("R4 open at +1", 32'(bank_open[3]), 1);
      for (int k = 2; k <= AP_D; k++) begin
         nop();
         chk($sformatf("R4 open at +%0d", k), 32'(bank_open[3]), (k < AP_D) ? 1 : 0);
      end
      cmd(C_WR, 1'b1, 2'd2, 13'h0400);
      repeat (AP_D - 1) nop();
      chk("R4 write-ap before", 32'(bank_open[2]), 1);
      nop();
      chk("R4 write-ap after", 32'(bank_open[2]), 0);
      chk("R4 others open", 32'(bank_open), 4'b0011);

      // R6 single-bank precharge
      cmd(C_PRE, 1'b1, 2'd0, 13'h1BFF);
      chk("R6 single close", 32'(bank_open), 4'b0010);

      // R7 access to closed banks
      cmd(C_RD, 1'b1, 2'd0, 13'h0000);
      chk("R7 read closed", 32'(err_code), 1);
      chk("R7 state kept", 32'(bank_open), 4'b0010);
      cmd(C_WR, 1'b1, 2'd3, 13'h0400);
      chk("R7 write closed", 32'(err_code), 1);

      // R9 refresh with a bank open
      cmd(C_REF, 1'b1, 2'd0, 13'h0000);
      chk("R9 refresh open", 32'(err_code), 3);
      cmd(C_REF, 1'b0, 2'd0, 13'h0000);
      chk("R9 sref open", 32'(err_code), 3);
      chk("R9 no sref", 32'(self_ref), 0);
      chk("R9 state kept", 32'(bank_open), 4'b0010);

      // R6 precharge all with a closed bank named
      cmd(C_PRE, 1'b1, 2'd3, 13'h0400);
      chk("R6 all close", 32'(bank_open), 0);
      cmd(C_REF, 1'b1, 2'd3, 13'h1FFF);
      chk("R9 auto refresh code", 32'(cmd_code), 6);
      chk("R9 auto refresh err", 32'(err), 0);

      // R8 mode loads
      cmd(C_LMR, 1'b1, 2'd0, 13'h0123);
      chk("R8 strobe", 32'(mr_we), 1);
      chk("R8 sel mode", 32'(mr_sel), 0);
      chk("R8 opcode", 32'(mr_opcode), 32'h0123);
      nop();
      chk("R8 strobe one cycle", 32'(mr_we), 0);
      cmd(C_LMR, 1'b1, 2'd1, 13'h1ABC);
      chk("R8 sel ext", 32'(mr_sel), 1);
      chk("R8 ext opcode", 32'(mr_opcode), 32'h1ABC);
      for (int b = 2; b < 4; b++) begin
         cmd(C_LMR, 1'b1, 2'(b), 13'h0555);
         chk("R8 reserved err", 32'(err_code), 5);
         chk("R8 reserved no strobe", 32'(mr_we), 0);
         chk("R8 reserved opcode kept", 32'(mr_opcode), 32'h1ABC);
         chk("R8 reserved sel kept", 32'(mr_sel), 1);
      end

      // R10 self-refresh
      cmd(C_REF, 1'b0, 2'd0, 13'h0000);
      chk("R10 enter", 32'(self_ref), 1);
      chk("R10 enter code", 32'(cmd_code), 7);
      cmd(C_ACT, 1'b0, 2'd0, 13'h0005);
      chk("R10 ignored code", 32'(cmd_code), 0);
      chk("R10 ignored open", 32'(bank_open), 0);
      cmd(C_LMR, 1'b0, 2'd2, 13'h0000);
      chk("R10 ignored err", 32'(err), 0);
      cmd(C_ACT, 1'b1, 2'd0, 13'h0005);
      chk("R10 exit", 32'(self_ref), 0);
      chk("R10 exit cmd ignored", 32'(bank_open), 0);
      cmd(C_ACT, 1'b1, 2'd0, 13'h0005);
      chk("R10 after exit open", 32'(bank_open), 1);
      chk("R10 after exit row", 32'(bank_row[0 +: 13]), 5);

      // R11 reset closes banks
      cmd(C_ACT, 1'b1, 2'd2, 13'h0042);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1;
      chk("R11 reset closes", 32'(bank_open), 0);
      chk("R11 reset code", 32'(cmd_code), 0);
      @(negedge clk);
      rst = 1'b0;

      report();
   end
endmodule